// File: doc/BRIEF.md
# Microsecond One-Shot Delay Timer

This block produces a single timed delay measured against a tick enable that pulses at the legacy interval-timer rate of 1193182 Hz. Software or a hardware sequencer strobes in a delay in microseconds. The block turns that value into a tick count by multiplying by 1193182 and then dividing by 1,000,000. Doing the multiply first keeps the fractional part until the final truncation. The result is clamped to a 16-bit latch, and the block then counts down on the tick enable. When the count is spent, a done bit in an 8-bit status byte goes high. The caller polls that bit. Typical delays are 10,000 µs (11931 ticks) and 200 µs (238 ticks), as used between the messages of a processor wake-up sequence.

The division is sequential: it retires one quotient bit per clock. Ticks that arrive during the conversion are not counted. The timer fires once and never reloads itself. It restarts only when a new load strobe arrives.

The controller has five named states:
- IDLE: after reset.
- DIVIDE: the conversion is running.
- LATCH: the clamped quotient is written into the counter.
- COUNT: the counter decrements on each tick.
- EXPIRED: the done bit is set and the counter rests at zero.

The transitions are as follows:
- load: from any state to DIVIDE.
- div_done: DIVIDE to LATCH.
- latch_written: LATCH to COUNT, unconditionally.
- terminal_tick: COUNT to EXPIRED, on a tick seen while the count is zero.

Top module: `usdelay_timer`

## Requirements
- R1: After reset, `status_o` reads 8'h00 and `count_o` reads 0.
- R2: A load produces a count of floor(usec × 1193182 / 1000000), with the multiply done before the divide. For example, 10000 gives 11931, 200 gives 238 and 1 gives 1.
- R3: When the converted count exceeds 65535, the loaded count is 65535. For example, 60000 µs gives 65535.
- R4: The new count appears on `count_o` no later than PROD_W+4 clocks after the load strobe, where PROD_W = US_W + 21. Ticks that arrive before that point do not change the loaded value.
- R5: While counting, each cycle with `tick_i` high lowers `count_o` by exactly one. A cycle without a tick leaves it unchanged.
- R6: The done bit is bit 5 of `status_o`, and all other status bits read 0. For a loaded count N, the done bit rises on the clock edge of the (N+1)-th tick; after N ticks it is still 0. A count of 0 therefore sets it on the first tick.
- R7: Once done is set, it stays set and `count_o` stays at 0 under any number of further ticks, until the next load. There is no automatic reload.
- R8: A load clears the done bit on the following clock edge and restarts the conversion with the new value. This applies whether the block is converting, counting or expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-cycle strobe that starts a new delay |
| usec_i | input | US_W | Requested delay in microseconds, sampled with `load_i` |
| tick_i | input | 1 | Tick enable at the 1193182 Hz rate |
| status_o | output | 8 | Status byte; bit 5 is the done flag |
| count_o | output | CNT_W | Remaining tick count |

## Verification
The bench builds the block with its default parameters:
- a 24-bit microsecond input;
- a 16-bit counter;
- the 1193182 Hz rate;
- a divisor of 1,000,000.

With these values, a 45-bit product and a 45-step division run in every test. A request of 60000 µs already overflows the 16-bit latch, so the saturation path can be reached with a short input. The full 10,000 µs delay also fits inside the run, which means the largest countdown the wake-up sequence needs is checked tick by tick to its terminal edge.

// File: rtl/usdt_pkg.sv
package usdt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIVIDE,
        S_LATCH,
        S_COUNT,
        S_EXPIRED
    } tmr_state_e;

endpackage

// File: rtl/usdt_divider.sv
// Restoring divider: one quotient bit per clock, constant divisor.
module usdt_divider #(
    parameter int N       = 45,
    parameter int DIVISOR = 1000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] dividend_i,
    output logic         done_o,
    output logic [N-1:0] quot_o
);
    localparam int R_W = $clog2(DIVISOR) + 1;
    localparam int C_W = $clog2(N + 1);

    logic [R_W-1:0] rem_q;
    logic [N-1:0]   dvd_q;
    logic [C_W-1:0] cnt_q;
    logic           done_q;

    logic [R_W:0]   trial;
    logic           ge;
    logic [R_W-1:0] diff;

    // Shift the next dividend bit into the partial remainder.
    assign trial = {rem_q, dvd_q[N-1]};
    assign ge    = (trial >= (R_W+1)'(DIVISOR));
    // When ge holds, the true difference is below DIVISOR, so the low R_W bits are exact.
    assign diff  = trial[R_W-1:0] - R_W'(DIVISOR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            dvd_q  <= dividend_i;
            cnt_q  <= C_W'(N);
            done_q <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q  <= ge ? diff : trial[R_W-1:0];
            dvd_q  <= {dvd_q[N-2:0], ge};
            cnt_q  <= cnt_q - C_W'(1);
            done_q <= (cnt_q == C_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quot_o = dvd_q;
endmodule

// File: rtl/usdt_saturate.sv
// Clamps a wide unsigned value into OUT_W bits.
module usdt_saturate #(
    parameter int IN_W  = 45,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  in_i,
    output logic [OUT_W-1:0] out_o
);
    generate
        if (IN_W > OUT_W) begin : g_clamp
            assign out_o = (|in_i[IN_W-1:OUT_W]) ? {OUT_W{1'b1}} : in_i[OUT_W-1:0];
        end else begin : g_pass
            assign out_o = OUT_W'(in_i);
        end
    endgenerate
endmodule

// File: rtl/usdt_downcounter.sv
// Loadable down counter that stops at zero; it flags a tick that finds it empty.
module usdt_downcounter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         tick_i,
    output logic [W-1:0] count_o,
    output logic         empty_tick_o
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= val_i;
        end else if (tick_i && (count_q != '0)) begin
            count_q <= count_q - W'(1);
        end
    end

    assign count_o      = count_q;
    assign empty_tick_o = tick_i && !load_i && (count_q == '0);
endmodule

// File: rtl/usdelay_timer.sv
module usdelay_timer #(
    parameter int US_W     = 24,
    parameter int CNT_W    = 16,
    parameter int CLK_HZ   = 1193182,
    parameter int US_PER_S = 1000000,
    parameter int DONE_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [US_W-1:0]  usec_i,
    input  logic             tick_i,
    output logic [7:0]       status_o,
    output logic [CNT_W-1:0] count_o
);
    import usdt_pkg::*;

    localparam int FACT_W = $clog2(CLK_HZ + 1);
    localparam int PROD_W = US_W + FACT_W;

    tmr_state_e        state_q, state_d;
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] div_quot;
    logic              div_done;
    logic [CNT_W-1:0]  sat_val;
    logic              tick_gate;
    logic              expire;
    logic              done_q;

    // Multiply first so no fraction is lost before the divide.
    assign product = PROD_W'(usec_i) * PROD_W'(CLK_HZ);

    usdt_divider #(.N(PROD_W), .DIVISOR(US_PER_S)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (load_i),
        .dividend_i (product),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    usdt_saturate #(.IN_W(PROD_W), .OUT_W(CNT_W)) u_sat (
        .in_i  (div_quot),
        .out_o (sat_val)
    );

    // Ticks are counted only while counting, and never in the cycle of a load.
    assign tick_gate = tick_i && !load_i && (state_q == S_COUNT);

    usdt_downcounter #(.W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (state_q == S_LATCH),
        .val_i        (sat_val),
        .tick_i       (tick_gate),
        .count_o      (count_o),
        .empty_tick_o (expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = S_DIVIDE;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_DIVIDE:  if (div_done) state_d = S_LATCH;
                S_LATCH:   state_d = S_COUNT;
                S_COUNT:   if (expire) state_d = S_EXPIRED;
                S_EXPIRED: state_d = S_EXPIRED;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // Output register: sticky done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (load_i) done_q <= 1'b0;
        else if (expire) done_q <= 1'b1;
    end

    generate
        for (genvar b = 0; b < 8; b++) begin : g_status
            if (b == DONE_BIT) begin : g_done
                assign status_o[b] = done_q;
            end else begin : g_zero
                assign status_o[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/usdt_checker.sv
module usdt_checker #(
    parameter int CNT_W    = 16,
    parameter int DONE_BIT = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_i,
    input logic                 tick_i,
    input logic [7:0]           status_o,
    input logic [CNT_W-1:0]     count_o,
    input usdt_pkg::tmr_state_e state,
    input logic                 quot_hi
);
    import usdt_pkg::*;

    logic counting, expired, latching;
    assign counting = (state == S_COUNT);
    assign expired  = (state == S_EXPIRED);
    assign latching = (state == S_LATCH);

    AST_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> !status_o[DONE_BIT]); // R8
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n) (counting && !tick_i) |=> $stable(count_o)); // R5
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n) (counting && tick_i && !load_i && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (status_o[DONE_BIT] && !load_i) |=> status_o[DONE_BIT]); // R7
    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(status_o[DONE_BIT]) |-> ($past(count_o) == '0 && $past(tick_i))); // R6
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (latching && quot_hi) |=> count_o == {CNT_W{1'b1}}); // R3
    AST_EXPIRED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (expired && !load_i) |=> count_o == '0); // R7
endmodule

bind usdelay_timer usdt_checker #(.CNT_W(CNT_W), .DONE_BIT(DONE_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .tick_i   (tick_i),
    .status_o (status_o),
    .count_o  (count_o),
    .state    (state_q),
    .quot_hi  (|div_quot[PROD_W-1:CNT_W])
);

// File: tb/tb_usdelay_timer.sv
module tb_usdelay_timer;
    localparam int US_W   = 24;
    localparam int CNT_W  = 16;
    localparam int PROD_W = US_W + 21;
    localparam int CONV_WAIT = PROD_W + 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_i = 1'b0;
    logic [US_W-1:0]  usec_i = '0;
    logic             tick_i = 1'b0;
    logic [7:0]       status_o;
    logic [CNT_W-1:0] count_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    usdelay_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .usec_i   (usec_i),
        .tick_i   (tick_i),
        .status_o (status_o),
        .count_o  (count_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic longint exp_ticks(input longint us);
        longint t;
        t = (us * 1193182) / 1000000;
        return (t > 65535) ? 65535 : t;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    // Load a value, optionally ticking during the conversion window.
    task automatic do_load(input longint v, input bit stray);
        @(negedge clk);
        load_i = 1'b1;
        usec_i = US_W'(v);
        @(negedge clk);
        load_i = 1'b0;
        for (int i = 0; i < CONV_WAIT; i++) begin
            tick_i = stray && (i < 10);
            @(negedge clk);
        end
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "status after reset", status_o, 8'h00);
        chk("R1", "count after reset", count_o, 0);
    endtask

    task automatic t_convert(input longint v);
        do_load(v, 1'b1);
        chk("R2", "converted count", count_o, exp_ticks(v));
        chk("R4", "stray ticks ignored, status", status_o, 8'h00);
    endtask

    task automatic t_countdown(input longint v);
        longint n;
        n = exp_ticks(v);
        do_load(v, 1'b0);
        chk("R2", "loaded count", count_o, n);
        ticks(int'(n));
        chk("R5", "count after N ticks", count_o, 0);
        chk("R6", "no done after N ticks", status_o, 8'h00);
        ticks(1);
        chk("R6", "done on tick N+1 (bit5)", status_o, 8'h20);
    endtask

    task automatic t_zero();
        do_load(0, 1'b0);
        chk("R6", "zero request count", count_o, 0);
        chk("R6", "zero request not done yet", status_o, 8'h00);
        ticks(1);
        chk("R6", "zero request done on first tick", status_o, 8'h20);
    endtask

    task automatic t_saturate();
        do_load(60000, 1'b0);
        chk("R3", "saturated count", count_o, 65535);
        ticks(3);
        chk("R5", "saturated count after 3 ticks", count_o, 65532);
    endtask

    task automatic t_oneshot();
        ticks(20);
        chk("R7", "done stays high", status_o, 8'h20);
        chk("R7", "count stays zero", count_o, 0);
    endtask

    task automatic t_reload();
        // Load after expiry clears done on the next edge.
        @(negedge clk);
        load_i = 1'b1;
        usec_i = US_W'(1);
        @(negedge clk);
        load_i = 1'b0;
        chk("R8", "done cleared by load", status_o, 8'h00);
        repeat (CONV_WAIT) @(negedge clk);
        chk("R8", "count after reload", count_o, 1);
        // Reload in the middle of a countdown.
        do_load(200, 1'b0);
        ticks(50);
        chk("R5", "mid-count value", count_o, 188);
        do_load(1000, 1'b0);
        chk("R8", "reload mid-count", count_o, exp_ticks(1000));
        // Reload in the middle of a conversion.
        @(negedge clk);
        load_i = 1'b1;
        usec_i = US_W'(10000);
        @(negedge clk);
        load_i = 1'b0;
        repeat (5) @(negedge clk);
        do_load(200, 1'b0);
        chk("R8", "reload mid-conversion", count_o, 238);
        // No tick: value holds.
        repeat (10) @(negedge clk);
        chk("R5", "holds without ticks", count_o, 238);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_convert(10000);
        t_convert(200);
        t_convert(1);
        t_convert(838);
        t_countdown(200);
        t_oneshot();
        t_zero();
        t_saturate();
        t_reload();
        t_countdown(10000);
        t_oneshot();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule